// File: doc/BRIEF.md
# Dependency-Graph Rail Sequencer

This block drives the enable pins of a set of supply rails. Each rail carries a mask of the rails it depends on. A rail is switched on only after every rail it depends on has shown power-good without a break for a programmed dwell. Power-down runs the graph backwards: a rail is released only once every rail that depends on it is off and has lost power-good. Both directions are guarded by a progress timeout. A stalled power-up rolls back by dropping every enable it has raised.

Once all rails are up, the block watches four fault classes on each enabled rail: over-current, under-voltage, over-voltage and over-temperature. Each of the first three has its own programmable action: latch, capped retry with doubling back-off, or fixed-period hiccup. Over-temperature always latches, and it is released only by a clear while the temperature-OK input is high. On a supply brown-out the block first requests a slower system clock. If the brown-out persists, it sheds the non-critical rails and then the critical ones. A dependency mask with a loop is refused before any rail is touched.

Top module: `rail_seq`

## Requirements
- R1: Power-up starts one cycle after `pwr_up_req` rises. A rail with an empty mask is enabled on the next cycle. Any other rail is enabled `dwell_cyc`+1 cycles after the last of its predecessors' power-good rises, provided each predecessor's power-good stays high throughout. Bit `i*NR+j` of `pred_map` set means rail i depends on rail j.
- R2: `up_done` rises `dwell_cyc`+1 cycles after the last rail's power-good rises. This requires all rails to be enabled.
- R3: Power-down begins when `pwr_up_req` falls, and `up_done` drops one cycle later. After that, each cycle releases every enabled rail whose dependants all have enable and power-good low. A rail is never released while a dependant is enabled.
- R4: During power-up, if the enables do not change for `step_limit`+1 cycles, all enables clear in one cycle. `seq_timeout` then rises and stays high until the next power-up start, and no rail is enabled until `pwr_up_req` has been dropped and raised again. During power-down the same stall forces every enable off.
- R5: Faults act only while `up_done` is high, and only on an enabled rail. The rail's enable drops on the next cycle and the other rails are unaffected. Priority is over-temperature, then over-voltage, then over-current, then under-voltage. Action codes are 00 latch, 01 retry, 10 or 11 hiccup.
- R6: The k-th retry (k counted from 0) holds the rail off for `backoff_base`·2^k + 1 cycles. After `retry_max` retries the next fault latches the rail and sets its `retry_exh` bit.
- R7: A hiccup holds the rail off for `hiccup_cyc`+1 cycles every time, without counting.
- R8: A latched rail stays off until `fault_clr`. An over-temperature latch also needs `temp_ok` high. A clear that is accepted re-enables the rail two cycles after `fault_clr` is sampled, and clears the retry count and `retry_exh`.
- R9: `cfg_err` is high whenever the dependency masks contain a self-dependency or a loop. While it is high, power-up does not start and all enables stay low.
- R10: On brown-out while up, `clk_reduce` rises one cycle later with no enable change. If brown-out lasts `shed_delay`+1 cycles, the rails with a clear `crit_mask` bit are released. After a further `shed_delay`+1 cycles all rails are off and `clk_reduce` drops. If brown-out ends before any shedding, `clk_reduce` drops and the rails stay on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_up_req | input | 1 | High requests rails on, low requests rails off |
| pg | input | NR | Power-good per rail |
| pred_map | input | NR*NR | Dependency masks, NR bits per rail |
| crit_mask | input | NR | Rails kept through the first shedding step |
| dwell_cyc | input | TW | Power-good hold time before dependants start |
| step_limit | input | TW | Progress timeout for both sequences |
| shed_delay | input | TW | Brown-out wait before each shedding step |
| backoff_base | input | TW | First retry off-time |
| hiccup_cyc | input | TW | Hiccup off-time |
| retry_max | input | RW | Retry cap |
| pol_oc | input | 2 | Over-current action |
| pol_uv | input | 2 | Under-voltage action |
| pol_ov | input | 2 | Over-voltage action |
| flt_oc | input | NR | Over-current flags |
| flt_uv | input | NR | Under-voltage flags |
| flt_ov | input | NR | Over-voltage flags |
| flt_ot | input | NR | Over-temperature flags |
| temp_ok | input | 1 | Temperature back in range |
| fault_clr | input | 1 | Clear request for latched rails |
| brownout | input | 1 | Input supply sag |
| rail_en | output | NR | Rail enables |
| clk_reduce | output | 1 | Request to slow the system clock |
| up_done | output | 1 | All rails up and settled |
| seq_timeout | output | 1 | Last sequence stalled |
| cfg_err | output | 1 | Dependency loop detected |
| rail_latched | output | NR | Rail held off by a latch |
| retry_exh | output | NR | Retry cap reached |

## Verification
Each result has a fixed latency counted in clock edges from its cause. A dependant's enable follows its predecessor's power-good by dwell+1 edges, and a rollback follows the last enable change by step_limit+1. A retry re-enable follows the fault edge by the computed off-time plus one, an accepted clear takes two edges, and a shedding step follows brown-out entry by shed_delay+1. The bench models power-good as the enable itself. It samples on the falling edge and counts falling edges from the first sample that shows the cause. Each measured count is compared with these closed-form values, so any rail that moves early or late registers as a miscompare.

// File: rtl/rail_seq.sv
module rail_seq #(
  parameter int NR = 4,
  parameter int TW = 16,
  parameter int RW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_up_req,
  input  logic [NR-1:0]    pg,
  input  logic [NR*NR-1:0] pred_map,
  input  logic [NR-1:0]    crit_mask,
  input  logic [TW-1:0]    dwell_cyc,
  input  logic [TW-1:0]    step_limit,
  input  logic [TW-1:0]    shed_delay,
  input  logic [TW-1:0]    backoff_base,
  input  logic [TW-1:0]    hiccup_cyc,
  input  logic [RW-1:0]    retry_max,
  input  logic [1:0]       pol_oc,
  input  logic [1:0]       pol_uv,
  input  logic [1:0]       pol_ov,
  input  logic [NR-1:0]    flt_oc,
  input  logic [NR-1:0]    flt_uv,
  input  logic [NR-1:0]    flt_ov,
  input  logic [NR-1:0]    flt_ot,
  input  logic             temp_ok,
  input  logic             fault_clr,
  input  logic             brownout,
  output logic [NR-1:0]    rail_en,
  output logic             clk_reduce,
  output logic             up_done,
  output logic             seq_timeout,
  output logic             cfg_err,
  output logic [NR-1:0]    rail_latched,
  output logic [NR-1:0]    retry_exh
);
  typedef enum logic [2:0] {S_IDLE, S_UP, S_ON, S_BROWN, S_DOWN, S_HOLD} st_t;
  localparam logic [1:0] F_OK = 2'd0, F_WAIT = 2'd1, F_LAT = 2'd2;

  st_t st, st_n;
  logic [NR-1:0] en_n, pg_ok, ready, can_off, hit, go_lat, back, lot;
  logic [NR-1:0][NR-1:0] reach, dep;
  logic [NR-1:0][TW-1:0] hc, wcnt;
  logic [NR-1:0][RW-1:0] rcnt;
  logic [NR-1:0][1:0] fst, psel;
  logic [TW-1:0] tmr;
  logic set_to, to_hit;

  assign up_done    = (st == S_ON);
  assign clk_reduce = (st == S_BROWN);
  assign to_hit     = (tmr >= step_limit);

  always_comb begin
    cfg_err = 1'b0;
    for (int i = 0; i < NR; i++) begin
      reach[i] = pred_map[i*NR +: NR];
      for (int j = 0; j < NR; j++) dep[i][j] = pred_map[j*NR + i];
    end
    for (int k = 0; k < NR; k++)
      for (int i = 0; i < NR; i++)
        for (int j = 0; j < NR; j++)
          if (reach[i][j]) reach[i] = reach[i] | pred_map[j*NR +: NR];
    for (int i = 0; i < NR; i++) cfg_err = cfg_err | reach[i][i];
  end

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      pg_ok[i]   = pg[i] && (hc[i] >= dwell_cyc);
      ready[i]   = (&(pg_ok | ~pred_map[i*NR +: NR])) && !rail_en[i] && fst[i] == F_OK;
      can_off[i] = rail_en[i] && !(|(dep[i] & (rail_en | pg)));
      psel[i]    = flt_ov[i] ? pol_ov : flt_oc[i] ? pol_oc : pol_uv;
      hit[i]     = up_done && rail_en[i] && fst[i] == F_OK &&
                   (flt_oc[i] | flt_uv[i] | flt_ov[i] | flt_ot[i]);
      go_lat[i]  = hit[i] && (flt_ot[i] || psel[i] == 2'b00 ||
                              (psel[i] == 2'b01 && rcnt[i] == retry_max));
      back[i]    = up_done && fst[i] == F_WAIT && wcnt[i] == '0;
      rail_latched[i] = (fst[i] == F_LAT);
    end
  end

  always_comb begin
    st_n = st;
    en_n = rail_en;
    set_to = 1'b0;
    case (st)
      S_IDLE: begin
        en_n = '0;
        if (pwr_up_req && !cfg_err) st_n = S_UP;
      end
      S_UP:
        if (!pwr_up_req) st_n = S_DOWN;
        else if (to_hit) begin en_n = '0; set_to = 1'b1; st_n = S_HOLD; end
        else if (&rail_en && &pg_ok) st_n = S_ON;
        else en_n = rail_en | ready;
      S_ON:
        if (!pwr_up_req) st_n = S_DOWN;
        else if (brownout) st_n = S_BROWN;
        else en_n = (rail_en & ~hit) | back;
      S_BROWN:
        if (!pwr_up_req) st_n = S_DOWN;
        else if (!brownout) st_n = S_ON;
        else if (tmr >= shed_delay) begin
          if (|(rail_en & ~crit_mask)) en_n = rail_en & crit_mask;
          else begin en_n = '0; st_n = S_HOLD; end
        end
      S_DOWN:
        if (to_hit) begin en_n = '0; set_to = 1'b1; st_n = S_IDLE; end
        else if (rail_en == '0) st_n = S_IDLE;
        else en_n = rail_en & ~can_off;
      S_HOLD:
        if (!pwr_up_req) st_n = S_DOWN;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; rail_en <= '0; tmr <= '0; seq_timeout <= 1'b0;
    end else begin
      st <= st_n;
      rail_en <= en_n;
      if (st_n != st || en_n != rail_en) tmr <= '0;
      else if (tmr != '1) tmr <= tmr + 1'b1;
      if (set_to) seq_timeout <= 1'b1;
      else if (st == S_IDLE && st_n == S_UP) seq_timeout <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hc <= '0; wcnt <= '0; rcnt <= '0; fst <= '0; lot <= '0; retry_exh <= '0;
    end else begin
      for (int i = 0; i < NR; i++) begin
        if (!pg[i]) hc[i] <= '0;
        else if (hc[i] < dwell_cyc) hc[i] <= hc[i] + 1'b1;
        if (fault_clr && !(fst[i] == F_LAT && lot[i] && !temp_ok)) begin
          rcnt[i] <= '0; retry_exh[i] <= 1'b0;
        end
        if (hit[i]) begin
          if (go_lat[i]) begin
            fst[i] <= F_LAT;
            lot[i] <= flt_ot[i];
            retry_exh[i] <= !flt_ot[i] && psel[i] == 2'b01;
          end else if (psel[i] == 2'b01) begin
            wcnt[i] <= backoff_base << rcnt[i];
            rcnt[i] <= rcnt[i] + 1'b1;
            fst[i]  <= F_WAIT;
          end else begin
            wcnt[i] <= hiccup_cyc;
            fst[i]  <= F_WAIT;
          end
        end else if (fst[i] == F_WAIT) begin
          if (wcnt[i] == '0) fst[i] <= F_OK;
          else wcnt[i] <= wcnt[i] - 1'b1;
        end else if (fst[i] == F_LAT && fault_clr && (!lot[i] || temp_ok)) begin
          fst[i]  <= F_WAIT;
          wcnt[i] <= '0;
        end
      end
    end

  p_rollback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_UP && st == S_HOLD) |-> (rail_en == '0 && seq_timeout));
  p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st == S_IDLE && cfg_err) |-> st == S_IDLE);
  p_clk_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_reduce) |-> rail_en == $past(rail_en));

  for (genvar g = 0; g < NR; g++) begin : g_chk
    p_dwell_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rail_en[g]) && $past(st) == S_UP) |->
        $past(&(pg_ok | ~pred_map[g*NR +: NR])));
    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DOWN && $fell(rail_en[g])) |-> (rail_en & dep[g]) == '0);
    p_fault_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hit[g]) |-> !rail_en[g]);
    p_exh_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
      retry_exh[g] |-> fst[g] == F_LAT);
    p_ot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fst[g] == F_LAT && lot[g] && !temp_ok) |=> fst[g] == F_LAT);
  end
endmodule

// File: tb/rail_seq_tb_top.sv
module rail_seq_tb_top;
  localparam int NR = 4, TW = 12, RW = 4;
  localparam logic [15:0] MAP_OK = 16'h1210, MAP_SELF = 16'h1410, MAP_LOOP = 16'h1214;

  logic clk = 1'b0, rst_n = 1'b0, pwr_up_req = 1'b0;
  logic [NR-1:0] pg, pg_blk = '0, crit_mask = 4'b0001;
  logic [NR*NR-1:0] pred_map = MAP_OK;
  logic [TW-1:0] dwell_cyc = 5, step_limit = 30, shed_delay = 10, backoff_base = 4, hiccup_cyc = 7;
  logic [RW-1:0] retry_max = 2;
  logic [1:0] pol_oc = 2'b00, pol_uv = 2'b01, pol_ov = 2'b10;
  logic [NR-1:0] flt_oc = '0, flt_uv = '0, flt_ov = '0, flt_ot = '0;
  logic temp_ok = 1'b1, fault_clr = 1'b0, brownout = 1'b0;
  logic [NR-1:0] rail_en, rail_latched, retry_exh;
  logic clk_reduce, up_done, seq_timeout, cfg_err;
  int vecs = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;
  assign pg = rail_en & ~pg_blk;

  rail_seq #(.NR(NR), .TW(TW), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_up_req(pwr_up_req), .pg(pg), .pred_map(pred_map),
    .crit_mask(crit_mask), .dwell_cyc(dwell_cyc), .step_limit(step_limit),
    .shed_delay(shed_delay), .backoff_base(backoff_base), .hiccup_cyc(hiccup_cyc),
    .retry_max(retry_max), .pol_oc(pol_oc), .pol_uv(pol_uv), .pol_ov(pol_ov),
    .flt_oc(flt_oc), .flt_uv(flt_uv), .flt_ov(flt_ov), .flt_ot(flt_ot),
    .temp_ok(temp_ok), .fault_clr(fault_clr), .brownout(brownout),
    .rail_en(rail_en), .clk_reduce(clk_reduce), .up_done(up_done),
    .seq_timeout(seq_timeout), .cfg_err(cfg_err), .rail_latched(rail_latched),
    .retry_exh(retry_exh));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act cycles=%0d exp <=150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cnt_bit(input int i, input logic v, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (rail_en[i] !== v && n < 400);
  endtask

  task automatic cnt_vec(input logic [NR-1:0] v, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (rail_en !== v && n < 400);
  endtask

  task automatic bring_up();
    pwr_up_req = 1'b1;
    for (int k = 0; k < 400 && !up_done; k++) @(negedge clk);
  endtask

  task automatic bring_down();
    pwr_up_req = 1'b0;
    for (int k = 0; k < 400 && rail_en != '0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_fault(input int kind, input int i);
    @(negedge clk);
    case (kind)
      0: flt_uv[i] = 1'b1;
      1: flt_ov[i] = 1'b1;
      2: begin flt_ov[i] = 1'b1; flt_uv[i] = 1'b1; end
      default: flt_ot[i] = 1'b1;
    endcase
    @(negedge clk);
    flt_uv = '0; flt_ov = '0; flt_ot = '0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("reset rail_en", rail_en, 0);
    chk("reset up_done", up_done, 0);
    chk("reset clk_reduce", clk_reduce, 0);
    chk("reset cfg_err", cfg_err, 0);
  endtask

  task automatic t_powerup();
    int n;
    @(negedge clk); pwr_up_req = 1'b1;
    cnt_bit(0, 1'b1, n); chk("R1 root rail start", n, 2);
    cnt_bit(1, 1'b1, n); chk("R1 dependant after dwell", n, 6);
    chk("R1 sibling rail3 together", rail_en[3], 1);
    chk("R1 rail2 still waiting", rail_en[2], 0);
    cnt_bit(2, 1'b1, n); chk("R1 second level", n, 6);
    n = 0;
    do begin @(negedge clk); n++; end while (!up_done && n < 400);
    chk("R2 up_done latency", n, 6);
  endtask

  task automatic t_powerdown();
    @(negedge clk); pwr_up_req = 1'b0;
    @(negedge clk); chk("R3 enter down", rail_en, 4'hf); chk("R3 up_done low", up_done, 0);
    @(negedge clk); chk("R3 leaves first", rail_en, 4'b0011);
    @(negedge clk); chk("R3 middle rail", rail_en, 4'b0001);
    @(negedge clk); chk("R3 root last", rail_en, 4'b0000);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_timeout();
    int n;
    pg_blk = 4'b0010;
    pwr_up_req = 1'b1;
    cnt_bit(1, 1'b1, n);
    chk("R4 partial up", rail_en, 4'b1011);
    cnt_vec(4'b0000, n); chk("R4 rollback latency", n, 31);
    chk("R4 seq_timeout set", seq_timeout, 1);
    pg_blk = 4'b0000;
    repeat (5) @(negedge clk);
    chk("R4 held after rollback", rail_en, 0);
    chk("R4 flag held", seq_timeout, 1);
    bring_down();
    pwr_up_req = 1'b1;
    @(negedge clk); chk("R4 flag cleared on restart", seq_timeout, 0);
    bring_up(); chk("R4 restart completes", up_done, 1);
  endtask

  task automatic t_retry();
    int n;
    pulse_fault(0, 1);
    chk("R5 faulted rail off", rail_en[1], 0);
    chk("R5 others untouched", rail_en & 4'b1101, 4'b1101);
    cnt_bit(1, 1'b1, n); chk("R6 first backoff", n, 5);
    pulse_fault(0, 1);
    cnt_bit(1, 1'b1, n); chk("R6 doubled backoff", n, 9);
    pulse_fault(0, 1);
    repeat (30) @(negedge clk);
    chk("R6 cap latches", rail_en[1], 0);
    chk("R6 retry_exh", retry_exh[1], 1);
    chk("R6 latched flag", rail_latched[1], 1);
    pulse_clr();
    cnt_bit(1, 1'b1, n); chk("R8 clear re-enables", n, 1);
    chk("R8 exh cleared", retry_exh[1], 0);
    pulse_fault(0, 1);
    cnt_bit(1, 1'b1, n); chk("R8 retry count reset", n, 5);
  endtask

  task automatic t_hiccup();
    int n;
    pol_uv = 2'b00;
    pulse_fault(2, 3);
    cnt_bit(3, 1'b1, n); chk("R5 ov over uv priority", n, 8);
    chk("R5 not latched", rail_latched[3], 0);
    pulse_fault(1, 3);
    cnt_bit(3, 1'b1, n); chk("R7 hiccup constant", n, 8);
    pol_uv = 2'b01;
  endtask

  task automatic t_ot();
    int n;
    temp_ok = 1'b0;
    pulse_fault(3, 2);
    repeat (20) @(negedge clk);
    chk("R8 ot latched", rail_en[2], 0);
    chk("R8 ot latch flag", rail_latched[2], 1);
    pulse_clr();
    repeat (10) @(negedge clk);
    chk("R8 clear ignored while hot", rail_en[2], 0);
    temp_ok = 1'b1;
    pulse_clr();
    cnt_bit(2, 1'b1, n); chk("R8 clear after cool", n, 1);
  endtask

  task automatic t_brown();
    int n;
    @(negedge clk); brownout = 1'b1;
    @(negedge clk); chk("R10 clk_reduce first", clk_reduce, 1);
    chk("R10 no rail change", rail_en, 4'hf);
    @(negedge clk); brownout = 1'b0;
    @(negedge clk); chk("R10 recovery drops request", clk_reduce, 0);
    chk("R10 rails kept", rail_en, 4'hf);
    brownout = 1'b1;
    @(negedge clk); chk("R10 request again", clk_reduce, 1);
    cnt_vec(4'b0001, n); chk("R10 non-critical shed", n, 11);
    cnt_vec(4'b0000, n); chk("R10 critical shed", n, 11);
    @(negedge clk); chk("R10 request dropped", clk_reduce, 0);
    brownout = 1'b0;
    bring_down();
  endtask

  task automatic t_cfg();
    pred_map = MAP_SELF;
    #1 chk("R9 self dependency", cfg_err, 1);
    pwr_up_req = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 refused self", rail_en, 0);
    pred_map = MAP_LOOP;
    #1 chk("R9 three-rail loop", cfg_err, 1);
    repeat (10) @(negedge clk);
    chk("R9 refused loop", rail_en, 0);
    chk("R9 not done", up_done, 0);
    pred_map = MAP_OK;
    #1 chk("R9 valid map", cfg_err, 0);
    bring_up(); chk("R9 start after fix", up_done, 1);
    bring_down();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_powerup();
    t_powerdown();
    t_timeout();
    t_retry();
    t_hiccup();
    t_ot();
    t_brown();
    t_cfg();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule